// File: doc/BRIEF.md
# Packed Video Min/Max Unit

This block is the datapath of a video-style minimum/maximum instruction in a GPU-like shader core. A 64-bit instruction word is presented together with three 32-bit source words, A, B and C, on a single-cycle strobe. The unit carves an 8-bit, 16-bit or full-width lane out of A and extends it with the signedness the instruction gives. B is either carved out of a register word the same way or taken from a 20-bit immediate field. The unit picks the smaller or larger of the two and gets the order right even when one operand is signed and the other is not. It can clamp that value to the signedness of the destination, and then combines it with C by a post-operation.

The post-operation can insert a halfword or a byte into C, add C with wrap-around, take a second minimum or maximum against C, or pass the value through unchanged. Register reads, writeback and flag generation belong to the surrounding pipeline.

The control is a two-state machine. `ST_IDLE` is the state with no result to present. `ST_EMIT` is the state in which the registered result is valid. The transition IDLE→EMIT is taken on an input strobe. EMIT→EMIT is taken on a strobe in the very next cycle. EMIT→IDLE is taken when no strobe arrives. Reset forces IDLE.

Top module: `pmm_unit`

## Requirements
- R1: The A lane width comes from instruction bits 38:37: code 2 is a halfword, code 3 is the full word, codes 0 and 1 are a byte. For a byte, bits 37:36 pick byte 0..3. For a halfword, only bit 36 is used, with 0 for the low half and 1 for the high half. For the full word, the lane is ignored.
- R2: The selected lane is moved down to bit 0. It is zero-extended when its operand is unsigned and sign-extended when signed. Bit 48 set means A is signed. A full-width lane passes unchanged.
- R3: When bit 50 is 1, B comes from the register word. Its width code is in bits 30:29 and its lane is in bits 29:28, with the same meaning as for A. Bit 49 set means B is signed.
- R4: When bit 50 is 0, B is the 20-bit immediate in bits 35:16. It is sign-extended from bit 35 when bit 49 is 1 and zero-extended otherwise.
- R5: Bit 56 selects the operation: 1 gives the maximum, 0 the minimum. When A and B share a signedness, they are compared with that signedness.
- R6: When A and B differ in signedness, the true numeric minimum or maximum is chosen. The maximum then counts as an unsigned result and the minimum as a signed result.
- R7: With bit 55 set, a result that counts as unsigned is clamped to at most 0x7FFFFFFF when bit 54 (destination signed) is 1. A result that counts as signed and is negative is clamped to 0 when bit 54 is 0. With bit 55 clear, no clamping occurs.
- R8: Post-operation code (bits 53:51) 0 writes the result's low 16 bits into C[31:16]. Code 1 writes them into C[15:0]. Code 2 writes the low 8 bits into C[7:0]. Code 3 writes the low 8 bits into C[23:16]. All other bits of C are kept.
- R9: Post-operation code 4 outputs result + C modulo 2^32.
- R10: Post-operation codes 5 and 6 output the minimum (5) or maximum (6) of the result and C. Both are compared signed when bit 54 is 1 and unsigned when it is 0.
- R11: Post-operation code 7 outputs the result unchanged.
- R12: The output word is registered on the clock edge at which the input strobe is high. The output valid is high in exactly the following cycle for each strobe.
- R13: Without a strobe, the output word holds its value and the inputs have no effect on it.
- R14: A synchronous active-high reset clears the output valid and the output word to 0 at the next edge, and reset overrides a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: instruction and sources are valid this cycle |
| insn | input | 64 | Instruction word |
| src_a | input | 32 | Source word A |
| src_b | input | 32 | Source word B (used when bit 50 is 1) |
| src_c | input | 32 | Source word C for the post-operation |
| out_valid | output | 1 | High for one cycle per accepted strobe |
| out_data | output | 32 | Registered result |

## Verification
The bench builds the unit with its default data width of 32, the only width at which the instruction's field positions and merge offsets are defined. At that width every lane choice, the signed 20-bit immediate edge, the 0x7FFFFFFF and zero clamps, and the wrap of the accumulate are reachable from the top ports. Directed vectors cover mixed-signedness orderings around 0x80000000 and each merge code. Fully random 64-bit instruction words, including the unused bits, are scored against a bench reference model that orders operands as 64-bit integers. The random strobe pattern also exercises back-to-back results and held outputs.

// File: rtl/pmm_pkg.sv
package pmm_pkg;

    localparam int unsigned INSN_W  = 64;
    localparam int unsigned IMM_W   = 20;
    localparam int unsigned BYTE_W  = 8;

    // instruction field positions (behavioural: decoded by this unit)
    localparam int unsigned A_WID_LO   = 37;
    localparam int unsigned A_LANE_LO  = 36;
    localparam int unsigned B_WID_LO   = 29;
    localparam int unsigned B_LANE_LO  = 28;
    localparam int unsigned IMM_LO     = 16;
    localparam int unsigned A_SIGN_BIT = 48;
    localparam int unsigned B_SIGN_BIT = 49;
    localparam int unsigned B_REG_BIT  = 50;
    localparam int unsigned POST_LO    = 51;
    localparam int unsigned DST_SG_BIT = 54;
    localparam int unsigned SAT_BIT    = 55;
    localparam int unsigned MAX_BIT    = 56;

    typedef enum logic [1:0] {
        LW_BYTE = 2'd0,
        LW_HALF = 2'd1,
        LW_WORD = 2'd2
    } lane_width_e;

    typedef enum logic [2:0] {
        PO_INS_HI16 = 3'd0,
        PO_INS_LO16 = 3'd1,
        PO_INS_B0   = 3'd2,
        PO_INS_B2   = 3'd3,
        PO_ACC      = 3'd4,
        PO_MIN      = 3'd5,
        PO_MAX      = 3'd6,
        PO_PASS     = 3'd7
    } post_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_e;

    typedef struct packed {
        lane_width_e width;
        logic [1:0]  lane;
        logic        is_signed;
    } opnd_ctl_t;

    typedef struct packed {
        opnd_ctl_t        a_ctl;
        opnd_ctl_t        b_ctl;
        logic             b_from_reg;
        logic [IMM_W-1:0] imm;
        logic             take_max;
        logic             sat_en;
        logic             dst_signed;
        post_op_e         post;
    } dec_t;

    function automatic lane_width_e width_of(input logic [1:0] code);
        case (code)
            2'd2:    return LW_HALF;
            2'd3:    return LW_WORD;
            default: return LW_BYTE;
        endcase
    endfunction

    function automatic logic [1:0] lane_of(input lane_width_e w, input logic [1:0] raw);
        case (w)
            LW_HALF: return {1'b0, raw[0]};
            LW_WORD: return 2'd0;
            default: return raw;
        endcase
    endfunction

endpackage

// File: rtl/pmm_decode.sv
module pmm_decode
    import pmm_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);

    logic        unused_insn_bits;
    lane_width_e a_w;
    lane_width_e b_w;

    assign unused_insn_bits = ^{insn[IMM_LO-1:0], insn[A_SIGN_BIT-1:A_WID_LO+2],
                                insn[INSN_W-1:MAX_BIT+1]};

    always_comb begin
        a_w = width_of(insn[A_WID_LO +: 2]);
        b_w = width_of(insn[B_WID_LO +: 2]);

        dec.a_ctl.width     = a_w;
        dec.a_ctl.lane      = lane_of(a_w, insn[A_LANE_LO +: 2]);
        dec.a_ctl.is_signed = insn[A_SIGN_BIT];

        dec.b_from_reg = insn[B_REG_BIT];
        if (insn[B_REG_BIT]) begin
            dec.b_ctl.width = b_w;
            dec.b_ctl.lane  = lane_of(b_w, insn[B_LANE_LO +: 2]);
        end else begin
            dec.b_ctl.width = LW_HALF;
            dec.b_ctl.lane  = 2'd0;
        end
        dec.b_ctl.is_signed = insn[B_SIGN_BIT];

        dec.imm        = insn[IMM_LO +: IMM_W];
        dec.take_max   = insn[MAX_BIT];
        dec.sat_en     = insn[SAT_BIT];
        dec.dst_signed = insn[DST_SG_BIT];
        dec.post       = post_op_e'(insn[POST_LO +: 3]);
    end

endmodule

// File: rtl/pmm_lane_extract.sv
module pmm_lane_extract
    import pmm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    input  opnd_ctl_t         ctl,
    output logic [DATA_W-1:0] ext
);

    localparam int unsigned HALF_W = DATA_W / 2;

    logic [BYTE_W-1:0] byte_v;
    logic [HALF_W-1:0] half_v;

    always_comb begin
        byte_v = word[BYTE_W*int'(ctl.lane) +: BYTE_W];
        half_v = word[HALF_W*int'(ctl.lane[0]) +: HALF_W];
        case (ctl.width)
            LW_BYTE: ext = {{(DATA_W-BYTE_W){ctl.is_signed & byte_v[BYTE_W-1]}}, byte_v};
            LW_HALF: ext = {{(DATA_W-HALF_W){ctl.is_signed & half_v[HALF_W-1]}}, half_v};
            default: ext = word;
        endcase
    end

    always_comb begin
        if (ctl.width == LW_BYTE && !ctl.is_signed) begin
            assert_byte_zero_ext_R2: assert (ext[DATA_W-1:BYTE_W] == '0);
        end
    end

endmodule

// File: rtl/pmm_select.sv
module pmm_select #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_val,
    input  logic              a_sgn,
    input  logic [DATA_W-1:0] b_val,
    input  logic              b_sgn,
    input  logic              take_max,
    input  logic              sat_en,
    input  logic              dst_signed,
    output logic [DATA_W-1:0] res
);

    localparam logic [DATA_W-1:0] POS_LIMIT = {1'b0, {(DATA_W-1){1'b1}}};

    logic [DATA_W:0]   a_w;
    logic [DATA_W:0]   b_w;
    logic              a_lt_b;
    logic [DATA_W-1:0] pick;
    logic              res_signed;

    always_comb begin
        a_w        = {a_sgn & a_val[DATA_W-1], a_val};
        b_w        = {b_sgn & b_val[DATA_W-1], b_val};
        a_lt_b     = $signed(a_w) < $signed(b_w);
        if (take_max) pick = a_lt_b ? b_val : a_val;
        else          pick = a_lt_b ? a_val : b_val;
        res_signed = (a_sgn == b_sgn) ? a_sgn : !take_max;

        res = pick;
        if (sat_en && dst_signed && !res_signed && pick[DATA_W-1]) res = POS_LIMIT;
        if (sat_en && !dst_signed && res_signed && pick[DATA_W-1]) res = '0;
    end

    always_comb begin
        if (take_max && !a_sgn && !b_sgn && !sat_en) begin
            assert_umax_bound_R5: assert (res >= a_val && res >= b_val);
        end
        if (sat_en && dst_signed && !res_signed) begin
            assert_sat_to_signed_R7: assert (!res[DATA_W-1]);
        end
        if (sat_en && !dst_signed && res_signed) begin
            assert_sat_to_unsigned_R7: assert (!res[DATA_W-1]);
        end
    end

endmodule

// File: rtl/pmm_post.sv
module pmm_post
    import pmm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] c_val,
    input  post_op_e          post,
    input  logic              dst_signed,
    output logic [DATA_W-1:0] out
);

    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W:0] r_w;
    logic [DATA_W:0] c_w;
    logic            r_lt_c;

    always_comb begin
        r_w    = {dst_signed & res[DATA_W-1], res};
        c_w    = {dst_signed & c_val[DATA_W-1], c_val};
        r_lt_c = $signed(r_w) < $signed(c_w);
        unique case (post)
            PO_INS_HI16: out = {res[HALF_W-1:0], c_val[HALF_W-1:0]};
            PO_INS_LO16: out = {c_val[DATA_W-1:HALF_W], res[HALF_W-1:0]};
            PO_INS_B0:   out = {c_val[DATA_W-1:BYTE_W], res[BYTE_W-1:0]};
            PO_INS_B2:   out = {c_val[DATA_W-1:HALF_W+BYTE_W], res[BYTE_W-1:0],
                                c_val[HALF_W-1:0]};
            PO_ACC:      out = res + c_val;
            PO_MIN:      out = r_lt_c ? res : c_val;
            PO_MAX:      out = r_lt_c ? c_val : res;
            PO_PASS:     out = res;
        endcase
    end

    always_comb begin
        if (post == PO_MIN && !dst_signed) begin
            assert_post_umin_bound_R10: assert (out <= res && out <= c_val);
        end
        if (post == PO_MAX && !dst_signed) begin
            assert_post_umax_bound_R10: assert (out >= res && out >= c_val);
        end
    end

endmodule

// File: rtl/pmm_unit.sv
module pmm_unit
    import pmm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSN_W-1:0]    insn,
    input  logic [DATA_W-1:0]    src_a,
    input  logic [DATA_W-1:0]    src_b,
    input  logic [DATA_W-1:0]    src_c,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_data
);

    localparam int unsigned N_OPND = 2;

    dec_t              dec;
    logic [DATA_W-1:0] opnd_word [N_OPND];
    opnd_ctl_t         opnd_ctl  [N_OPND];
    logic [DATA_W-1:0] opnd_ext  [N_OPND];
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] b_val;
    logic [DATA_W-1:0] mm_res;
    logic [DATA_W-1:0] post_out;
    out_state_e        state_q;
    out_state_e        state_d;
    logic [DATA_W-1:0] data_q;

    pmm_decode u_decode (
        .insn (insn),
        .dec  (dec)
    );

    assign opnd_word[0] = src_a;
    assign opnd_word[1] = src_b;
    assign opnd_ctl[0]  = dec.a_ctl;
    assign opnd_ctl[1]  = dec.b_ctl;

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_lane
        pmm_lane_extract #(.DATA_W(DATA_W)) u_extract (
            .word (opnd_word[gi]),
            .ctl  (opnd_ctl[gi]),
            .ext  (opnd_ext[gi])
        );
    end

    always_comb begin
        if (dec.b_ctl.is_signed)
            imm_ext = {{(DATA_W-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
        else
            imm_ext = {{(DATA_W-IMM_W){1'b0}}, dec.imm};
        b_val = dec.b_from_reg ? opnd_ext[1] : imm_ext;
    end

    pmm_select #(.DATA_W(DATA_W)) u_select (
        .a_val      (opnd_ext[0]),
        .a_sgn      (dec.a_ctl.is_signed),
        .b_val      (b_val),
        .b_sgn      (dec.b_ctl.is_signed),
        .take_max   (dec.take_max),
        .sat_en     (dec.sat_en),
        .dst_signed (dec.dst_signed),
        .res        (mm_res)
    );

    pmm_post #(.DATA_W(DATA_W)) u_post (
        .res        (mm_res),
        .c_val      (src_c),
        .post       (dec.post),
        .dst_signed (dec.dst_signed),
        .out        (post_out)
    );

    // next-state: strobe drives IDLE->EMIT and EMIT->EMIT, absence drives ->IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           data_q <= '0;
        else if (in_valid) data_q <= post_out;
    end

    assign out_valid = (state_q == ST_EMIT);
    assign out_data  = data_q;

    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_without_strobe_R13: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    assert_result_captured_R12: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_data == $past(post_out)));

endmodule

// File: tb/tb_pmm_unit.sv
module tb_pmm_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] insn;
    logic [31:0] src_a, src_b, src_c;
    logic        out_valid;
    logic [31:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmm_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // numeric value of a lane, per R1/R2 (field = width code + lane bits)
    function automatic longint lane_num(input logic [31:0] w, input logic [2:0] f, input logic s);
        longint v;
        if (f[2:1] == 2'd3) begin
            v = longint'(w);
            if (s && w[31]) v = v - 64'sd4294967296;
        end else if (f[2:1] == 2'd2) begin
            v = longint'((w >> (16 * f[0])) & 32'hFFFF);
            if (s && v >= 32768) v = v - 65536;
        end else begin
            v = longint'((w >> (8 * f[1:0])) & 32'hFF);
            if (s && v >= 128) v = v - 256;
        end
        return v;
    endfunction

    function automatic logic [31:0] ref_model(input logic [63:0] i, input logic [31:0] a,
                                              input logic [31:0] b, input logic [31:0] c);
        longint va, vb, r, rv, cv;
        logic as_, bs_, rs, ds;
        logic [31:0] r32;
        as_ = i[48];
        bs_ = i[49];
        ds  = i[54];
        va  = lane_num(a, i[38:36], as_);
        if (i[50]) vb = lane_num(b, i[30:28], bs_);
        else begin
            vb = longint'(i[35:16]);
            if (bs_ && i[35]) vb = vb - 1048576;
        end
        r  = i[56] ? ((va > vb) ? va : vb) : ((va < vb) ? va : vb);
        rs = (as_ == bs_) ? as_ : !i[56];
        if (i[55] && ds && !rs && r > 64'sh7FFFFFFF) r = 64'sh7FFFFFFF;
        if (i[55] && !ds && rs && r < 0) r = 0;
        r32 = r[31:0];
        rv = ds ? longint'($signed(r32)) : longint'(r32);
        cv = ds ? longint'($signed(c))   : longint'(c);
        case (i[53:51])
            3'd0: return {r32[15:0], c[15:0]};
            3'd1: return {c[31:16], r32[15:0]};
            3'd2: return {c[31:8], r32[7:0]};
            3'd3: return {c[31:24], r32[7:0], c[15:0]};
            3'd4: return r32 + c;
            3'd5: return (rv < cv) ? r32 : c;
            3'd6: return (rv > cv) ? r32 : c;
            default: return r32;
        endcase
    endfunction

    function automatic logic [63:0] mk(input logic [2:0] af, input logic as_,
                                       input logic [2:0] bf, input logic bs_, input logic breg,
                                       input logic [19:0] imm, input logic mx, input logic sat,
                                       input logic ds, input logic [2:0] post);
        logic [63:0] i = '0;
        i[38:36] = af;  i[48] = as_; i[49] = bs_; i[50] = breg;
        if (breg) i[30:28] = bf; else i[35:16] = imm;
        i[56] = mx; i[55] = sat; i[54] = ds; i[53:51] = post;
        return i;
    endfunction

    task automatic run(input logic [63:0] i, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic [31:0] exp, input string tag);
        @(negedge clk);
        insn = i; src_a = a; src_b = b; src_c = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        check(tag, out_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] held, pend;
        logic        pend_v;
        void'($urandom(32'd90210));
        rst = 1'b1; in_valid = 1'b0; insn = '0; src_a = '0; src_b = '0; src_c = '0;
        repeat (3) @(negedge clk);
        check("R14 reset valid", {31'd0, out_valid}, 32'd0);
        check("R14 reset data", out_data, 32'd0);
        rst = 1'b0;

        // R1 R2: signed byte lane 2 min against unsigned imm 0 -> signed -128
        run(mk(3'b010, 1, 0, 0, 0, 20'h0, 0, 0, 0, 3'd7), 32'h0080_0000, 0, 0,
            32'hFFFF_FF80, "R1 R2 signed byte lane2");
        // R1: unsigned high halfword, min with imm 0xFFFFF
        run(mk(3'b101, 0, 0, 0, 0, 20'hFFFFF, 0, 0, 0, 3'd7), 32'hABCD_1234, 0, 0,
            32'h0000_ABCD, "R1 high half");
        // R1: halfword ignores lane bit 37 (code 2 is bits 38:37=10)
        run(mk(3'b100, 1, 0, 1, 0, 20'h0, 0, 0, 0, 3'd7), 32'h1234_8001, 0, 0,
            32'hFFFF_8001, "R1 R2 signed low half");
        // R4: signed immediate 0xFFFFF = -1 vs unsigned word 16
        run(mk(3'b110, 0, 0, 1, 0, 20'hFFFFF, 0, 0, 0, 3'd7), 32'h10, 0, 0,
            32'hFFFF_FFFF, "R4 R6 signed imm");
        // R4: unsigned immediate zero-extended
        run(mk(3'b110, 0, 0, 0, 0, 20'hFFFFF, 1, 0, 0, 3'd7), 32'h10, 0, 0,
            32'h000F_FFFF, "R4 unsigned imm");
        // R3: register B, unsigned byte lane 3
        run(mk(3'b000, 0, 3'b011, 0, 1, 0, 1, 0, 0, 3'd7), 32'h01, 32'hC300_0000, 0,
            32'h0000_00C3, "R3 B byte lane3");
        // R6: unsigned 0x80000000 vs signed 5
        run(mk(3'b110, 0, 3'b110, 1, 1, 0, 0, 0, 0, 3'd7), 32'h8000_0000, 32'd5, 0,
            32'd5, "R6 mixed min");
        run(mk(3'b110, 0, 3'b110, 1, 1, 0, 1, 0, 0, 3'd7), 32'h8000_0000, 32'd5, 0,
            32'h8000_0000, "R6 mixed max");
        // R5: both signed
        run(mk(3'b110, 1, 3'b110, 1, 1, 0, 0, 0, 0, 3'd7), 32'h8000_0000, 32'd5, 0,
            32'h8000_0000, "R5 signed min");
        run(mk(3'b110, 1, 3'b110, 1, 1, 0, 1, 0, 0, 3'd7), 32'h8000_0000, 32'd5, 0,
            32'd5, "R5 signed max");
        // R7: saturation
        run(mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 1, 1, 3'd7), 32'hF000_0000, 0, 0,
            32'h7FFF_FFFF, "R7 clamp to signed");
        run(mk(3'b110, 1, 3'b110, 1, 1, 0, 0, 1, 0, 3'd7), 32'hFFFF_FF00, 0, 0,
            32'h0, "R7 clamp to unsigned");
        run(mk(3'b110, 1, 3'b110, 1, 1, 0, 0, 0, 0, 3'd7), 32'hFFFF_FF00, 0, 0,
            32'hFFFF_FF00, "R7 no sat");
        // R8: merges with result 0x1234ABCD into C 0x55667788
        run(mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd0), 32'h1234_ABCD, 32'h1234_ABCD,
            32'h5566_7788, 32'hABCD_7788, "R8 merge hi16");
        run(mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd1), 32'h1234_ABCD, 32'h1234_ABCD,
            32'h5566_7788, 32'h5566_ABCD, "R8 merge lo16");
        run(mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd2), 32'h1234_ABCD, 32'h1234_ABCD,
            32'h5566_7788, 32'h5566_77CD, "R8 merge byte0");
        run(mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd3), 32'h1234_ABCD, 32'h1234_ABCD,
            32'h5566_7788, 32'h55CD_7788, "R8 merge byte2");
        // R9: accumulate wraps
        run(mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd4), 32'hFFFF_FFF0, 0, 32'h20,
            32'h10, "R9 acc wrap");
        // R10: post min/max by destination signedness; result 0x80000000, C = 1
        run(mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 1, 3'd5), 32'h8000_0000, 0, 32'd1,
            32'h8000_0000, "R10 post min signed");
        run(mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd5), 32'h8000_0000, 0, 32'd1,
            32'd1, "R10 post min unsigned");
        run(mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 1, 3'd6), 32'h8000_0000, 0, 32'd1,
            32'd1, "R10 post max signed");
        run(mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd6), 32'h8000_0000, 0, 32'd1,
            32'h8000_0000, "R10 post max unsigned");
        // R11: pass ignores C
        run(mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd7), 32'h0BAD_F00D, 0, 32'hFFFF_FFFF,
            32'h0BAD_F00D, "R11 pass");

        // R12 R13: valid drops and data holds while inputs change without strobe
        held = out_data;
        insn = {$urandom, $urandom}; src_a = $urandom; src_b = $urandom; src_c = $urandom;
        @(negedge clk);
        check("R12 single pulse", {31'd0, out_valid}, 32'd0);
        check("R13 hold", out_data, held);

        // random mix with random strobe pattern (back-to-back included)
        pend_v = 1'b0; pend = '0;
        for (int k = 0; k < 400; k++) begin
            in_valid = ($urandom % 4) != 0;
            insn = {$urandom, $urandom}; src_a = $urandom; src_b = $urandom; src_c = $urandom;
            pend_v = in_valid;
            pend   = in_valid ? ref_model(insn, src_a, src_b, src_c) : held;
            @(negedge clk);
            check("R12 random valid", {31'd0, out_valid}, {31'd0, pend_v});
            check(pend_v ? "R5-R11 random data" : "R13 random hold", out_data, pend);
            held = out_data;
        end

        // R14: reset wins over a strobe
        in_valid = 1'b1; rst = 1'b1;
        insn = mk(3'b110, 0, 3'b110, 0, 1, 0, 1, 0, 0, 3'd7); src_a = 32'h1111_1111;
        @(negedge clk);
        check("R14 reset valid", {31'd0, out_valid}, 32'd0);
        check("R14 reset data", out_data, 32'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule